// File: doc/BRIEF.md
# Memory-Map Address Decoder with Access Checks

This block sits on the single request path from a processor to six targets: a boot ROM, main DRAM, a serial-port register window, a timer register window, a general device window and a high vector/debug window. Each accepted request is matched against a fixed address table. A legal request is forwarded to exactly one target with the address rebased to the start of that target's window. The block then passes that target's read data back to the requester, with an OKAY response.

Before forwarding, the block checks three things. The address must fall in a mapped window. A wide access must be aligned to its own size. The access must respect the window's attributes: the boot ROM cannot be written, and instruction fetches are refused from the register and device windows. Any violation gives a response code for that class of fault and never reaches a target. This matters because reading some device registers has side effects. Only one request can be in flight at a time.

Top module: `memmap_decoder`

## Requirements
- R1: Addresses 0x0000_0000..0x0000_FFFF map to target 0, the boot ROM, and fetches there are forwarded. A write to this window returns PERM_ERR (code 3), and no target select is raised.
- R2: Addresses 0x1000_0000..0x1FFF_FFFF map to target 0x1 (DRAM), with reads, writes and fetches allowed. At most one bit of `tgt_sel` is ever high.
- R3: Addresses 0x4000_0000..0x4000_0FFF map to target 2 (serial registers). Addresses 0x4000_1000..0x4000_1FFF map to target 3 (timer registers).
- R4: Addresses 0x4000_2000..0x4FFF_FFFF map to target 4 (devices). Addresses 0xFFFF_0000..0xFFFF_FFFF map to target 5 (vector/debug), which allows fetches.
- R5: Any other address, including the reserved span 0x0001_0000..0x000F_FFFF, returns DECODE_ERR (code 1) and raises no select.
- R6: `req_size` encodes the access width: 0 = byte, 1 = halfword, 2 = word, 3 = doubleword. An address that is not a multiple of the width returns MISALIGN (code 2) and is not forwarded.
- R7: A fetch (`req_fetch`=1) from target 2, 3 or 4 returns PERM_ERR (code 3) and is not forwarded.
- R8: When several faults apply, the response reports decode error first, then misalignment, then permission.
- R9: A forwarded request shows the address minus its window base on `tgt_offset`. It also presents the request's size, write flag, write data and byte strobes.
- R10: The select and the offset stay stable until the selected target raises its ready bit. In that same cycle `rsp_valid` is high, `rsp_resp` is OKAY (code 0), and `rsp_rdata` carries that target's read data. The select drops after that edge.
- R11: A faulting request gives `rsp_valid` exactly one cycle after acceptance, with `rsp_rdata` equal to zero.
- R12: `req_ready` is high only when no request is in flight. After reset the block is idle, with no select and no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle; a request is accepted when valid and ready are both high |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | Access width code |
| req_write | input | 1 | 1 = write |
| req_fetch | input | 1 | 1 = instruction fetch |
| req_wdata | input | DATA_W | Write data |
| req_strb | input | DATA_W/8 | Byte strobes |
| tgt_sel | output | 6 | One-hot target select |
| tgt_offset | output | ADDR_W | Address relative to the window base |
| tgt_size | output | 2 | Forwarded width code |
| tgt_write | output | 1 | Forwarded write flag |
| tgt_wdata | output | DATA_W | Forwarded write data |
| tgt_strb | output | DATA_W/8 | Forwarded strobes |
| tgt_ready | input | 6 | Per-target completion |
| tgt_rdata | input | 6*DATA_W | Per-target read data, target i at bits i*DATA_W |
| rsp_valid | output | 1 | Response present |
| rsp_resp | output | 2 | 0 OKAY, 1 DECODE_ERR, 2 MISALIGN, 3 PERM_ERR |
| rsp_rdata | output | DATA_W | Read data, zero on faults |

## Verification
A request accepted at a clock edge either shows a select in the very next cycle or, if it faults, shows the fault response in that next cycle and nowhere else. The OKAY response arrives in the same cycle that the bench's target model raises ready, after a chosen wait of zero to three cycles. The bench drives inputs on the falling edge. It computes the expected target, offset and code from its own address table, and compares every output in every cycle of each transaction. It also confirms that the block returns to idle on the following cycle.

// File: rtl/memmap_pkg.sv
// Shared definitions for the memory-map decoder: response codes and the
// region table (window base, span and attributes). Region index i is the
// bit position of that window in the one-hot target select.
package memmap_pkg;

    localparam int ADDR_W  = 32;
    localparam int DATA_W  = 64;
    localparam int NUM_RGN = 6;

    typedef enum logic [1:0] {
        RESP_OKAY     = 2'd0,
        RESP_DECODE   = 2'd1,
        RESP_MISALIGN = 2'd2,
        RESP_PERM     = 2'd3
    } resp_e;

    // Window bases: ROM, DRAM, serial, timer, devices, vector/debug
    localparam logic [31:0] RGN_BASE [NUM_RGN] = '{
        32'h0000_0000, 32'h1000_0000, 32'h4000_0000,
        32'h4000_1000, 32'h4000_2000, 32'hFFFF_0000
    };

    // Last address minus base for each window
    localparam logic [31:0] RGN_SPAN [NUM_RGN] = '{
        32'h0000_FFFF, 32'h0FFF_FFFF, 32'h0000_0FFF,
        32'h0000_0FFF, 32'h0FFF_DFFF, 32'h0000_FFFF
    };

    // Attribute masks, bit i = region i
    localparam logic [NUM_RGN-1:0] RGN_EXEC  = 6'b100011;
    localparam logic [NUM_RGN-1:0] RGN_WRITE = 6'b111110;

endpackage

// File: rtl/memmap_region_match.sv
// Compares an address against every window of the region table in parallel.
// Produces a hit vector (at most one bit set, since windows do not overlap)
// and the address rebased to the hit window. Assumes window bases are aligned
// to the widest access, so rebasing keeps alignment.
module memmap_region_match
    import memmap_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int NR = NUM_RGN
) (
    input  logic [AW-1:0] addr,
    output logic [NR-1:0] hit,
    output logic [AW-1:0] offset
);

    logic [AW-1:0] rel [NR];

    // One unsigned range compare per window
    for (genvar gi = 0; gi < NR; gi++) begin : g_rgn
        assign rel[gi] = addr - AW'(RGN_BASE[gi]);
        assign hit[gi] = (rel[gi] <= AW'(RGN_SPAN[gi]));
    end

    // AND-OR select of the rebased address from the hit window
    always_comb begin
        offset = '0;
        for (int i = 0; i < NR; i++) begin
            if (hit[i]) offset = offset | rel[i];
        end
    end

endmodule

// File: rtl/memmap_access_check.sv
// Classifies a request as legal or one of three faults, in fixed priority:
// unmapped, then misaligned, then permission. Assumes hit is one-hot or zero.
module memmap_access_check
    import memmap_pkg::*;
#(
    parameter int NR = NUM_RGN
) (
    input  logic [NR-1:0] hit,
    input  logic [2:0]    addr_lo,
    input  logic [1:0]    size,
    input  logic          write,
    input  logic          fetch,
    output resp_e         code
);

    logic [3:0] width;
    logic       unmapped;
    logic       misaligned;
    logic       denied;

    // Fault detection and priority encode
    always_comb begin
        width      = 4'd1 << size;
        unmapped   = (hit == '0);
        misaligned = |(addr_lo & 3'(width - 4'd1));
        denied     = (write && |(hit & ~RGN_WRITE[NR-1:0])) ||
                     (fetch && |(hit & ~RGN_EXEC[NR-1:0]));
        if (unmapped)        code = RESP_DECODE;
        else if (misaligned) code = RESP_MISALIGN;
        else if (denied)     code = RESP_PERM;
        else                 code = RESP_OKAY;
    end

endmodule

// File: rtl/memmap_resp_mux.sv
// Returns the ready bit and read data of the selected target. Assumes the
// select is one-hot or zero; with no select both outputs are zero.
module memmap_resp_mux #(
    parameter int NR = 6,
    parameter int DW = 64
) (
    input  logic [NR-1:0]    sel,
    input  logic [NR-1:0]    ready_in,
    input  logic [NR*DW-1:0] rdata_in,
    output logic             ready_out,
    output logic [DW-1:0]    rdata_out
);

    // AND-OR collapse of per-target responses
    always_comb begin
        ready_out = 1'b0;
        rdata_out = '0;
        for (int i = 0; i < NR; i++) begin
            if (sel[i]) begin
                ready_out = ready_out | ready_in[i];
                rdata_out = rdata_out | rdata_in[i*DW +: DW];
            end
        end
    end

endmodule

// File: rtl/memmap_decoder.sv
// Memory-map decoder top. Accepts one request while idle, then either holds
// a one-hot select and rebased offset until that target is ready, or returns
// a fault code one cycle later without touching any target. Assumes targets
// keep rdata valid in the cycle they raise ready.
module memmap_decoder
    import memmap_pkg::*;
#(
    parameter int ADDR_W = memmap_pkg::ADDR_W,
    parameter int DATA_W = memmap_pkg::DATA_W,
    localparam int NR     = NUM_RGN,
    localparam int STRB_W = DATA_W / 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [1:0]           req_size,
    input  logic                 req_write,
    input  logic                 req_fetch,
    input  logic [DATA_W-1:0]    req_wdata,
    input  logic [STRB_W-1:0]    req_strb,
    output logic [NR-1:0]        tgt_sel,
    output logic [ADDR_W-1:0]    tgt_offset,
    output logic [1:0]           tgt_size,
    output logic                 tgt_write,
    output logic [DATA_W-1:0]    tgt_wdata,
    output logic [STRB_W-1:0]    tgt_strb,
    input  logic [NR-1:0]        tgt_ready,
    input  logic [NR*DATA_W-1:0] tgt_rdata,
    output logic                 rsp_valid,
    output logic [1:0]           rsp_resp,
    output logic [DATA_W-1:0]    rsp_rdata
);

    typedef enum logic [1:0] {ST_IDLE, ST_BUSY, ST_FAULT} state_e;

    state_e              state;
    logic [NR-1:0]       hit;
    logic [ADDR_W-1:0]   rebased;
    resp_e               code;
    logic                accept;
    logic [NR-1:0]       sel_q;
    resp_e               fault_q;
    logic                pick_ready;
    logic [DATA_W-1:0]   pick_rdata;

    memmap_region_match #(.AW(ADDR_W), .NR(NR)) u_match (
        .addr   (req_addr),
        .hit    (hit),
        .offset (rebased)
    );

    memmap_access_check #(.NR(NR)) u_check (
        .hit     (hit),
        .addr_lo (req_addr[2:0]),
        .size    (req_size),
        .write   (req_write),
        .fetch   (req_fetch),
        .code    (code)
    );

    memmap_resp_mux #(.NR(NR), .DW(DATA_W)) u_mux (
        .sel       (sel_q),
        .ready_in  (tgt_ready),
        .rdata_in  (tgt_rdata),
        .ready_out (pick_ready),
        .rdata_out (pick_rdata)
    );

    // Request acceptance only while idle
    assign req_ready = (state == ST_IDLE);
    assign accept    = req_valid && req_ready;

    // Control FSM: idle, waiting on a target, or returning a fault
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            sel_q   <= '0;
            fault_q <= RESP_OKAY;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        if (code != RESP_OKAY) begin
                            fault_q <= code;
                            state   <= ST_FAULT;
                        end else begin
                            sel_q <= hit;
                            state <= ST_BUSY;
                        end
                    end
                end
                ST_BUSY: begin
                    if (pick_ready) begin
                        sel_q <= '0;
                        state <= ST_IDLE;
                    end
                end
                default: begin
                    fault_q <= RESP_OKAY;
                    state   <= ST_IDLE;
                end
            endcase
        end
    end

    // Capture of forwarded request fields on a legal accept
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_offset <= '0;
            tgt_size   <= '0;
            tgt_write  <= 1'b0;
            tgt_wdata  <= '0;
            tgt_strb   <= '0;
        end else if (accept && code == RESP_OKAY) begin
            tgt_offset <= rebased;
            tgt_size   <= req_size;
            tgt_write  <= req_write;
            tgt_wdata  <= req_wdata;
            tgt_strb   <= req_strb;
        end
    end

    // Target select is live only while waiting on a target
    assign tgt_sel = (state == ST_BUSY) ? sel_q : '0;

    // Response generation for both the target path and the fault path
    always_comb begin
        rsp_valid = 1'b0;
        rsp_resp  = RESP_OKAY;
        rsp_rdata = '0;
        if (state == ST_FAULT) begin
            rsp_valid = 1'b1;
            rsp_resp  = fault_q;
        end else if (state == ST_BUSY && pick_ready) begin
            rsp_valid = 1'b1;
            rsp_rdata = pick_rdata;
        end
    end

endmodule

// File: rtl/memmap_decoder_chk.sv
// Protocol checker for the memory-map decoder, attached by bind.
module memmap_decoder_chk #(
    parameter int AW = 32,
    parameter int DW = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic [5:0]    tgt_sel,
    input logic [AW-1:0] tgt_offset,
    input logic [1:0]    tgt_size,
    input logic          tgt_write,
    input logic          rsp_valid,
    input logic [1:0]    rsp_resp,
    input logic [DW-1:0] rsp_rdata
);

    a_r2_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tgt_sel));

    a_r1_rom_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_sel[0] |-> !tgt_write);

    a_r6_forward_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_sel != 6'd0) |-> ((tgt_offset[2:0] & ((3'd1 << tgt_size) - 3'd1)) == 3'd0));

    a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_sel != 6'd0 && !rsp_valid) |=> ($stable(tgt_sel) && $stable(tgt_offset)));

    a_r11_fault_no_sel: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_resp != 2'd0) |-> (tgt_sel == 6'd0 && rsp_rdata == '0));

    a_r11_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> ((tgt_sel != 6'd0) || (rsp_valid && rsp_resp != 2'd0)));

    a_r12_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_sel != 6'd0 || rsp_valid) |-> !req_ready);

endmodule

bind memmap_decoder memmap_decoder_chk #(.AW(ADDR_W), .DW(DATA_W)) u_chk (.*);

// File: tb/tb_memmap_decoder.sv
`timescale 1ns/1ps
module tb_memmap_decoder;

    localparam int AW = 32;
    localparam int DW = 64;
    localparam int NR = 6;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic [AW-1:0]   req_addr = '0;
    logic [1:0]      req_size = '0;
    logic            req_write = 1'b0;
    logic            req_fetch = 1'b0;
    logic [DW-1:0]   req_wdata = '0;
    logic [DW/8-1:0] req_strb = '0;
    logic [NR-1:0]   tgt_sel;
    logic [AW-1:0]   tgt_offset;
    logic [1:0]      tgt_size;
    logic            tgt_write;
    logic [DW-1:0]   tgt_wdata;
    logic [DW/8-1:0] tgt_strb;
    logic [NR-1:0]   tgt_ready = '0;
    logic [NR*DW-1:0] tgt_rdata;
    logic            rsp_valid;
    logic [1:0]      rsp_resp;
    logic [DW-1:0]   rsp_rdata;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    memmap_decoder dut (.*);

    // Target responders: each returns a tag and the offset it was given
    for (genvar gi = 0; gi < NR; gi++) begin : g_tgt
        assign tgt_rdata[gi*DW +: DW] = {8'hC0 + 8'(gi), 24'h0, tgt_offset};
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Behavioural reference: target index, window base and response code
    function automatic void ref_model(input logic [31:0] a, input logic [1:0] sz,
                                      input logic w, input logic f,
                                      output int idx, output logic [31:0] base,
                                      output logic [1:0] resp);
        idx = -1; base = 0;
        if (a <= 32'h0000_FFFF) begin idx = 0; base = 32'h0; end
        else if (a >= 32'h1000_0000 && a <= 32'h1FFF_FFFF) begin idx = 1; base = 32'h1000_0000; end
        else if (a >= 32'h4000_0000 && a <= 32'h4000_0FFF) begin idx = 2; base = 32'h4000_0000; end
        else if (a >= 32'h4000_1000 && a <= 32'h4000_1FFF) begin idx = 3; base = 32'h4000_1000; end
        else if (a >= 32'h4000_2000 && a <= 32'h4FFF_FFFF) begin idx = 4; base = 32'h4000_2000; end
        else if (a >= 32'hFFFF_0000) begin idx = 5; base = 32'hFFFF_0000; end
        if (idx < 0) resp = 2'd1;
        else if ((a % (32'd1 << sz)) != 0) resp = 2'd2;
        else if ((w && idx == 0) || (f && (idx >= 2 && idx <= 4))) resp = 2'd3;
        else resp = 2'd0;
    endfunction

    // One complete transaction, checked on every cycle until idle again
    task automatic do_req(input string req, input logic [31:0] a, input logic [1:0] sz,
                          input logic w, input logic f, input int delay);
        int idx; logic [31:0] base; logic [1:0] resp;
        logic [63:0] wd;
        ref_model(a, sz, w, f, idx, base, resp);
        wd = {a, ~a};
        @(negedge clk);
        chk({req, "/R12 ready idle"}, 64'(req_ready), 64'd1);
        req_valid = 1'b1; req_addr = a; req_size = sz; req_write = w;
        req_fetch = f; req_wdata = wd; req_strb = 8'h5A;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        if (resp != 2'd0) begin
            #1;
            chk({req, "/R11 fault valid"}, 64'(rsp_valid), 64'd1);
            chk({req, "/R8 fault code"}, 64'(rsp_resp), 64'(resp));
            chk({req, "/R11 fault rdata"}, rsp_rdata, 64'd0);
            chk({req, "/R11 no select"}, 64'(tgt_sel), 64'd0);
            chk({req, "/R12 busy"}, 64'(req_ready), 64'd0);
        end else begin
            for (int c = 0; c <= delay; c++) begin
                tgt_ready = (c == delay) ? (6'd1 << idx) : 6'd0;
                #1;
                chk({req, "/R2 select"}, 64'(tgt_sel), 64'(6'd1 << idx));
                chk({req, "/R10 offset"}, 64'(tgt_offset), 64'(a - base));
                chk({req, "/R10 rsp timing"}, 64'(rsp_valid), 64'(c == delay));
                if (c == 0) begin
                    chk({req, "/R9 fields"}, {tgt_size, tgt_write, tgt_strb},
                        {sz, w, 8'h5A});
                    chk({req, "/R9 wdata"}, tgt_wdata, wd);
                end
                if (c == delay) begin
                    chk({req, "/R10 resp"}, 64'(rsp_resp), 64'd0);
                    chk({req, "/R10 rdata"}, rsp_rdata,
                        {8'hC0 + 8'(idx), 24'h0, a - base});
                end
                @(posedge clk);
                @(negedge clk);
            end
            tgt_ready = '0;
        end
        if (resp != 2'd0) begin
            @(posedge clk);
            @(negedge clk);
        end
        #1;
        chk({req, "/R12 back idle"}, {62'(tgt_sel), rsp_valid, req_ready}, 64'd1);
    endtask

    // Watchdog: a hung run is a failed check and still prints the summary
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R12 reset state", {62'(tgt_sel), rsp_valid, req_ready}, 64'd1);
        rst_n = 1'b1;
        // legal traffic per window
        do_req("R1 rom read",       32'h0000_0100, 2'd2, 0, 0, 0);
        do_req("R1 rom fetch top",  32'h0000_FFFC, 2'd2, 0, 1, 1);
        do_req("R2 dram write",     32'h1000_0008, 2'd3, 1, 0, 2);
        do_req("R2 dram top",       32'h1FFF_FFF8, 2'd3, 0, 1, 0);
        do_req("R3 uart last byte", 32'h4000_0FFF, 2'd0, 1, 0, 3);
        do_req("R3 timer base",     32'h4000_1000, 2'd2, 0, 0, 1);
        do_req("R4 dev base",       32'h4000_2000, 2'd1, 1, 0, 0);
        do_req("R4 dev top",        32'h4FFF_FFFE, 2'd1, 0, 0, 2);
        do_req("R4 debug fetch",    32'hFFFF_FFF0, 2'd3, 0, 1, 1);
        do_req("R6 byte odd ok",    32'h1000_0003, 2'd0, 0, 0, 0);
        // faults
        do_req("R1 rom write",      32'h0000_0010, 2'd2, 1, 0, 0);
        do_req("R5 reserved",       32'h0001_0000, 2'd2, 0, 0, 0);
        do_req("R5 gap",            32'h2000_0000, 2'd0, 0, 0, 0);
        do_req("R5 below dram",     32'h0FFF_FFFF, 2'd0, 1, 0, 0);
        do_req("R6 word misalign",  32'h1000_0002, 2'd2, 0, 0, 0);
        do_req("R6 double misalign",32'h1000_0004, 2'd3, 1, 0, 0);
        do_req("R7 uart fetch",     32'h4000_0000, 2'd2, 0, 1, 0);
        do_req("R7 timer fetch",    32'h4000_1004, 2'd2, 0, 1, 0);
        do_req("R7 dev fetch",      32'h4000_3000, 2'd2, 0, 1, 0);
        do_req("R8 misalign over perm", 32'h0000_0001, 2'd1, 1, 0, 0);
        do_req("R8 decode over misalign", 32'h0001_0001, 2'd2, 0, 0, 0);
        do_req("R8 misalign fetch", 32'h4000_0002, 2'd2, 0, 1, 0);
        // back-to-back legal after faults
        do_req("R10 after faults",  32'h1234_5670, 2'd3, 0, 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule